// File: doc/BRIEF.md
# Pixel Line Serializer

This block turns one video line of 1-bit pixels into a continuous serial bitstream. Pixel words are held in a small word FIFO that is smaller than the line. A line-start strobe flushes the FIFO and asks the data source for enough words to fill it. Shifting begins only once the FIFO is full. As the line drains, the block asks for the next fixed-size chunk each time the FIFO falls to half occupancy. When the whole line has been requested, the request stays quiet until the next line-start, so the data source is left alone during blanking.

The data source sees a request output and answers with one word per cycle on an acknowledge strobe. The bit rate is the clock divided by an even programmable divisor. After the last bit of the line, or whenever the FIFO runs dry too early, the output is held low, which is black. A premature empty condition also raises a sticky underrun flag.

With the default parameters (16-bit words, 8-word FIFO, 512-pixel line) a line is 32 words: one 8-word fill followed by six 4-word refills.

Top module: `pixel_line_serializer`

## Requirements
- R1: While reset is held and in the cycle after it, `pix_out`, `fill_req` and `underrun` are all 0.
- R2: A `line_start` pulse discards any stored words and any pending request, and from the next cycle holds `fill_req` high until 8 words (the FIFO depth) have been accepted. A pulse in the middle of a line restarts the line the same way.
- R3: No pixel is shifted until the FIFO holds 8 words after a line start, and `pix_out` stays 0 until then. Each word is sent most-significant bit (bit 15) first.
- R4: Each pixel bit is held on `pix_out` for exactly 2*N clock cycles, where N is the value of `bit_div`. A `bit_div` of 0 acts as 1.
- R5: Consecutive words of a line follow each other with no idle cycle. Over a line, the number of high cycles on `pix_out` equals the number of 1 bits in the accepted words times 2*N.
- R6: While a line is shifting, no chunk is pending, and fewer than 32 words have been requested for the line, a FIFO holding 4 words or fewer raises a request for a 4-word chunk. An undisturbed line therefore shows exactly 7 separate request bursts.
- R7: Exactly 32 words are accepted per line. After the 32nd word, `fill_req` stays 0 until the next `line_start`.
- R8: After the last bit of the 32nd word has been held for its full period, `pix_out` is 0 until the next `line_start`.
- R9: If a new word is needed before 32 words have been sent and the FIFO is empty, `underrun` is set to 1 and `pix_out` is 0 for that bit slot. The flag stays set until the next `line_start`, which clears it.
- R10: `fill_ack` is ignored while `fill_req` is 0: no word is stored, and the line's content and word count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle pulse that begins a new line |
| bit_div | input | 8 | Half bit period N in clock cycles (bit time = 2*N) |
| fill_ack | input | 1 | Data source presents one word this cycle |
| fill_data | input | 16 | Pixel word, bit 15 shown first |
| fill_req | output | 1 | Block wants more words |
| pix_out | output | 1 | Serial pixel bit, 0 is black |
| underrun | output | 1 | Sticky flag: FIFO ran dry mid-line |

## Verification
The bench goes after the refill threshold and the per-line gating. A threshold that is off by one word, or a gate that is never cleared, shows up as the wrong number of request bursts, as a 33rd word being taken, or as a request appearing during blanking. It also drives a divisor of 0, slow and bursty sources, stray acknowledges while the request is low, a source stall long enough to drain the FIFO mid-line, and a line-start in the middle of a line. These cases catch a design that stores stray words, inserts a gap between words, sends least-significant bit first, never sets or never clears the underrun flag, or carries stale words into a restarted line. Every cycle is compared against a behavioural queue model, and a separate per-line count of high cycles against the ones in the accepted words catches a wrong bit period.

// File: rtl/lsr_pkg.sv
// Shared types for the pixel line serializer.
// Assumes: nothing beyond standard SystemVerilog.
package lsr_pkg;

    // Line progress: idle in blanking, filling the FIFO, or shifting pixels.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_RUN  = 2'd2
    } line_phase_t;

endpackage

// File: rtl/lsr_word_fifo.sv
// Word FIFO for pixel data with a synchronous flush.
// Assumes: DEPTH is a power of two; the caller never pushes into a full
// FIFO and never pops an empty one. A flush wins over push and pop.
module lsr_word_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] pop_data,
    output logic [CW-1:0]     count,
    output logic              empty
);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wr_ptr_q;
    logic [AW-1:0]     rd_ptr_q;
    logic [CW-1:0]     count_q;

    // Storage write: data only, no reset needed.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem_q[wr_ptr_q] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Head word and status outputs.
    always_comb begin
        pop_data = mem_q[rd_ptr_q];
        count    = count_q;
        empty    = (count_q == '0);
    end

endmodule

// File: rtl/lsr_bit_timer.sv
// Bit-slot timer: one tick every 2*N cycles while enabled.
// Assumes: a divisor of 0 is treated as 1. The tick falls in the first
// enabled cycle, so the first bit slot opens at once.
module lsr_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] eff_div;
    logic [DIV_W:0]   limit;
    logic [DIV_W:0]   cnt_q;

    // Effective divisor and the last count value of a slot.
    always_comb begin
        eff_div = (half_div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : half_div;
        limit   = {eff_div, 1'b0} - {{DIV_W{1'b0}}, 1'b1};
        tick    = enable && (cnt_q == '0);
    end

    // Slot counter, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (cnt_q >= limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lsr_refill_ctrl.sv
// Line sequencer and refill requester.
// Line start: request a full FIFO. Once full: shift. While shifting: request
// a half-FIFO chunk whenever occupancy is at or below half, until the whole
// line has been requested.
// Assumes: fifo_cnt is the registered occupancy; line_end comes from the
// shifter when the last word has left.
module lsr_refill_ctrl #(
    parameter int DEPTH      = 8,
    parameter int LINE_WORDS = 32,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic [CW-1:0] fifo_cnt,
    input  logic          fill_ack,
    input  logic          line_end,
    output logic          fill_req,
    output logic          accept,
    output logic          running
);
    import lsr_pkg::*;

    localparam int HALF = DEPTH / 2;
    localparam int IW   = $clog2(LINE_WORDS + 1);

    line_phase_t   phase_q;
    logic [CW-1:0] chunk_q;
    logic [IW-1:0] issued_q;
    logic          want_refill;

    // Request, acceptance and refill decision.
    always_comb begin
        fill_req    = (chunk_q != '0);
        accept      = fill_req && fill_ack && !line_start;
        running     = (phase_q == PH_RUN);
        want_refill = running && (chunk_q == '0)
                      && (issued_q < IW'(LINE_WORDS))
                      && (fifo_cnt <= CW'(HALF));
    end

    // Line phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (line_start) begin
            phase_q <= PH_FILL;
        end else if (phase_q == PH_FILL && fifo_cnt == CW'(DEPTH)) begin
            phase_q <= PH_RUN;
        end else if (phase_q == PH_RUN && line_end) begin
            phase_q <= PH_IDLE;
        end
    end

    // Outstanding chunk size and words requested so far this line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chunk_q  <= '0;
            issued_q <= '0;
        end else if (line_start) begin
            chunk_q  <= CW'(DEPTH);
            issued_q <= IW'(DEPTH);
        end else if (accept) begin
            chunk_q  <= chunk_q - 1'b1;
        end else if (want_refill) begin
            chunk_q  <= CW'(HALF);
            issued_q <= issued_q + IW'(HALF);
        end
    end

endmodule

// File: rtl/lsr_shifter.sv
// Pixel shifter: sends each word most-significant bit first, one bit per
// tick, and pulls the next word in the same tick the previous one ends.
// Gives black and flags underrun when a word is due but the FIFO is empty.
// Assumes: ticks only come while the line is shifting.
module lsr_shifter #(
    parameter int WORD_W     = 16,
    parameter int LINE_WORDS = 32,
    localparam int BW        = $clog2(WORD_W),
    localparam int SW        = $clog2(LINE_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              tick,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    output logic              pop,
    output logic              line_end,
    output logic              pix_out,
    output logic              underrun
);

    logic [WORD_W-1:0] shreg_q;
    logic [BW-1:0]     bits_q;
    logic [SW-1:0]     sent_q;
    logic              pix_q;
    logic              under_q;
    logic              need_word;

    // Word fetch and end-of-line detection.
    always_comb begin
        need_word = tick && (bits_q == '0);
        pop       = need_word && !fifo_empty;
        line_end  = need_word && fifo_empty && (sent_q == SW'(LINE_WORDS));
        pix_out   = pix_q;
        underrun  = under_q;
    end

    // Shift register, bit and word counters, output bit and underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n || line_start) begin
            shreg_q <= '0;
            bits_q  <= '0;
            sent_q  <= '0;
            pix_q   <= 1'b0;
            under_q <= 1'b0;
        end else if (tick) begin
            if (bits_q != '0) begin
                pix_q   <= shreg_q[WORD_W-1];
                shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                bits_q  <= bits_q - 1'b1;
            end else if (!fifo_empty) begin
                pix_q   <= fifo_word[WORD_W-1];
                shreg_q <= {fifo_word[WORD_W-2:0], 1'b0};
                bits_q  <= BW'(WORD_W - 1);
                sent_q  <= sent_q + 1'b1;
            end else begin
                pix_q <= 1'b0;
                if (sent_q < SW'(LINE_WORDS)) begin
                    under_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pixel_line_serializer.sv
// Pixel line serializer top: word FIFO, refill sequencer, bit timer and
// shifter. A line-start pulse fills the FIFO, shifting starts when it is
// full, half-empty refills keep it fed, and the request is gated off once
// the whole line has been requested.
// Assumes: LINE_PIXELS is a multiple of WORD_W and of (FIFO_DEPTH/2)*WORD_W
// beyond the first fill; FIFO_DEPTH is a power of two.
module pixel_line_serializer #(
    parameter int WORD_W      = 16,
    parameter int FIFO_DEPTH  = 8,
    parameter int LINE_PIXELS = 512,
    parameter int DIV_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic              fill_ack,
    input  logic [WORD_W-1:0] fill_data,
    output logic              fill_req,
    output logic              pix_out,
    output logic              underrun
);

    localparam int LINE_WORDS = LINE_PIXELS / WORD_W;
    localparam int CW         = $clog2(FIFO_DEPTH + 1);

    logic [CW-1:0]     fifo_cnt;
    logic              fifo_empty;
    logic [WORD_W-1:0] fifo_word;
    logic              push;
    logic              pop;
    logic              tick;
    logic              running;
    logic              line_end;

    lsr_word_fifo #(
        .WORD_W (WORD_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (line_start),
        .push      (push),
        .push_data (fill_data),
        .pop       (pop),
        .pop_data  (fifo_word),
        .count     (fifo_cnt),
        .empty     (fifo_empty)
    );

    lsr_refill_ctrl #(
        .DEPTH      (FIFO_DEPTH),
        .LINE_WORDS (LINE_WORDS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .fifo_cnt   (fifo_cnt),
        .fill_ack   (fill_ack),
        .line_end   (line_end),
        .fill_req   (fill_req),
        .accept     (push),
        .running    (running)
    );

    lsr_bit_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (running),
        .half_div (bit_div),
        .tick     (tick)
    );

    lsr_shifter #(
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .tick       (tick),
        .fifo_empty (fifo_empty),
        .fifo_word  (fifo_word),
        .pop        (pop),
        .line_end   (line_end),
        .pix_out    (pix_out),
        .underrun   (underrun)
    );

endmodule

// File: rtl/lsr_checker.sv
// Assertion checker for the pixel line serializer, bound to the top.
// Assumes: fifo_cnt and running are the top's internal occupancy and
// shifting state.
module lsr_checker #(
    parameter int DEPTH      = 8,
    parameter int LINE_WORDS = 32,
    parameter int CW         = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_start,
    input logic          fill_req,
    input logic          fill_ack,
    input logic          pix_out,
    input logic          underrun,
    input logic          running,
    input logic [CW-1:0] fifo_cnt
);

    int acc_q;

    // Words accepted since the last line start.
    always_ff @(posedge clk) begin
        if (!rst_n || line_start) begin
            acc_q <= 0;
        end else if (fill_req && fill_ack) begin
            acc_q <= acc_q + 1;
        end
    end

    // R6: refills never push the FIFO past its depth.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    // R3: shifting starts only from a full FIFO.
    assert_start_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(fifo_cnt) == CW'(DEPTH));

    // R7: never more than a line's worth of words accepted.
    assert_word_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= LINE_WORDS);

    // R7: no request once the line's words are all in.
    assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> acc_q < LINE_WORDS);

    // R8: black whenever the line is not shifting.
    assert_black_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pix_out);

    // R9: the slot that raises underrun is black.
    assert_underrun_black_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> !pix_out);

    // R10: an acknowledge without request leaves the FIFO untouched.
    assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ack && !fill_req && !line_start && !running) |=> $stable(fifo_cnt));

endmodule

bind pixel_line_serializer lsr_checker #(
    .DEPTH      (FIFO_DEPTH),
    .LINE_WORDS (LINE_WORDS),
    .CW         (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .fill_req   (fill_req),
    .fill_ack   (fill_ack),
    .pix_out    (pix_out),
    .underrun   (underrun),
    .running    (running),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/pixel_line_serializer_tb.sv
// Bench: behavioural queue model compared every cycle, plus per-line checks.
module pixel_line_serializer_tb;

    localparam int WORD_W     = 16;
    localparam int DEPTH      = 8;
    localparam int HALF       = DEPTH / 2;
    localparam int LINE_WORDS = 32;
    localparam int DIV_W      = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_start = 1'b0;
    logic [DIV_W-1:0]  bit_div = 8'd1;
    logic              fill_ack = 1'b0;
    logic [WORD_W-1:0] fill_data = '0;
    logic              fill_req;
    logic              pix_out;
    logic              underrun;

    always #2 clk = ~clk;

    pixel_line_serializer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .bit_div    (bit_div),
        .fill_ack   (fill_ack),
        .fill_data  (fill_data),
        .fill_req   (fill_req),
        .pix_out    (pix_out),
        .underrun   (underrun)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit src_hold = 1'b0;
    bit garbage_en = 1'b0;
    int lat_max = 0;
    int wait_cnt = 0;

    // Reference model state.
    logic [WORD_W-1:0] m_q[$];
    int                m_phase = 0;  // 0 blank, 1 fill, 2 shifting
    int                m_chunk = 0;
    int                m_issued = 0;
    int                m_cnt = 0;
    int                m_bits = 0;
    int                m_sent = 0;
    logic [WORD_W-1:0] m_sh = '0;
    logic              m_dout = 1'b0;
    logic              m_under = 1'b0;

    // Per-line observations.
    int acc_line = 0;
    int ones_exp = 0;
    int hi_cnt = 0;
    int req_rises = 0;
    bit prev_req = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural model, one update per clock.
    always @(posedge clk) begin
        int occ, lim, eff;
        bit req, run, tick, empty, acc, lend;
        logic [WORD_W-1:0] w;
        if (!rst_n) begin
            m_q.delete();
            m_phase = 0; m_chunk = 0; m_issued = 0; m_cnt = 0;
            m_bits = 0; m_sent = 0; m_sh = '0; m_dout = 0; m_under = 0;
        end else if (line_start) begin
            m_q.delete();
            m_phase = 1; m_chunk = DEPTH; m_issued = DEPTH;
            m_cnt = (m_phase == 2) ? m_cnt : 0;
            m_bits = 0; m_sent = 0; m_sh = '0; m_dout = 0; m_under = 0;
        end else begin
            occ   = m_q.size();
            req   = (m_chunk != 0);
            run   = (m_phase == 2);
            tick  = run && (m_cnt == 0);
            empty = (occ == 0);
            acc   = req && fill_ack;
            lend  = tick && (m_bits == 0) && empty && (m_sent == LINE_WORDS);
            eff   = (bit_div == 0) ? 1 : int'(bit_div);
            lim   = 2 * eff - 1;
            if (!run) m_cnt = 0;
            else if (m_cnt >= lim) m_cnt = 0;
            else m_cnt++;
            if (m_phase == 1 && occ == DEPTH) m_phase = 2;
            else if (m_phase == 2 && lend) m_phase = 0;
            if (acc) m_chunk--;
            else if (run && m_chunk == 0 && m_issued < LINE_WORDS && occ <= HALF) begin
                m_chunk = HALF;
                m_issued += HALF;
            end
            if (tick) begin
                if (m_bits != 0) begin
                    m_dout = m_sh[WORD_W-1];
                    m_sh = m_sh << 1;
                    m_bits--;
                end else if (!empty) begin
                    w = m_q.pop_front();
                    m_dout = w[WORD_W-1];
                    m_sh = w << 1;
                    m_bits = WORD_W - 1;
                    m_sent++;
                end else begin
                    m_dout = 1'b0;
                    if (m_sent < LINE_WORDS) m_under = 1'b1;
                end
            end
            if (acc) m_q.push_back(fill_data);
        end
    end

    // Line statistics from the ports.
    always @(posedge clk) begin
        if (!rst_n || line_start) begin
            acc_line = 0; ones_exp = 0; hi_cnt = 0; req_rises = 0; prev_req = 0;
        end else begin
            if (fill_req && fill_ack) begin
                acc_line++;
                ones_exp += $countones(fill_data);
            end
            if (pix_out) hi_cnt++;
            if (fill_req && !prev_req) req_rises++;
            prev_req = fill_req;
        end
    end

    // Cycle compare against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(pix_out === m_dout, "R3 R4 R5 R8", "pix_out", int'(pix_out), int'(m_dout));
            chk(fill_req === (m_chunk != 0), "R2 R6 R7", "fill_req", int'(fill_req), int'(m_chunk != 0));
            chk(underrun === m_under, "R9", "underrun", int'(underrun), int'(m_under));
        end
    end

    // Data source: random latency, optional hold, optional stray acks (R10).
    always @(negedge clk) begin
        if (!rst_n) begin
            fill_ack = 1'b0;
        end else if (fill_req && !src_hold) begin
            if (wait_cnt > 0) begin
                fill_ack = 1'b0;
                wait_cnt--;
            end else begin
                fill_ack  = 1'b1;
                fill_data = WORD_W'($urandom);
                wait_cnt  = $urandom_range(lat_max, 0);
            end
        end else if (fill_req) begin
            fill_ack = 1'b0;
        end else begin
            fill_ack  = garbage_en ? 1'($urandom_range(1, 0)) : 1'b0;
            fill_data = WORD_W'($urandom);
        end
    end

    task automatic run_line(input int n, input int lat, input bit garb,
                            input bit stall, input int abort_after);
        int eff;
        bit_div    = DIV_W'(n);
        lat_max    = lat;
        garbage_en = garb;
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        chk(fill_req == 1'b1, "R2", "request after line start", int'(fill_req), 1);
        chk(pix_out == 1'b0, "R3", "black while filling", int'(pix_out), 0);
        chk(underrun == 1'b0, "R9", "underrun cleared by line start", int'(underrun), 0);
        if (abort_after > 0) begin
            repeat (abort_after) @(negedge clk);
            return;
        end
        if (stall) begin
            repeat (300) @(negedge clk);
            src_hold = 1'b1;
            repeat (600) @(negedge clk);
            chk(underrun == 1'b1, "R9", "underrun after source stall", int'(underrun), 1);
            src_hold = 1'b0;
        end
        while (m_phase != 0) @(negedge clk);
        eff = (n == 0) ? 1 : n;
        chk(acc_line == LINE_WORDS, "R7 R10", "words accepted", acc_line, LINE_WORDS);
        chk(req_rises == 7, "R6", "request bursts", req_rises, 7);
        chk(hi_cnt == ones_exp * 2 * eff, "R4 R5", "high cycles", hi_cnt, ones_exp * 2 * eff);
        garbage_en = 1'b1;
        repeat (48) begin
            @(negedge clk);
            chk(fill_req == 1'b0, "R7", "request quiet in blanking", int'(fill_req), 0);
            chk(pix_out == 1'b0, "R8", "black after line", int'(pix_out), 0);
        end
        chk(acc_line == LINE_WORDS, "R10", "stray acks not taken", acc_line, LINE_WORDS);
        if (stall) chk(underrun == 1'b1, "R9", "underrun sticky", int'(underrun), 1);
        garbage_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (3) @(negedge clk);
        chk(pix_out == 1'b0, "R1", "pix_out in reset", int'(pix_out), 0);
        chk(fill_req == 1'b0, "R1", "fill_req in reset", int'(fill_req), 0);
        chk(underrun == 1'b0, "R1", "underrun in reset", int'(underrun), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fill_req == 1'b0 && pix_out == 1'b0 && underrun == 1'b0, "R1",
            "outputs after reset", int'({fill_req, pix_out, underrun}), 0);
        cmp_en = 1'b1;
        run_line(1, 2, 1'b0, 1'b0, 0);
        run_line(3, 5, 1'b1, 1'b0, 0);
        run_line(0, 0, 1'b0, 1'b0, 0);
        run_line(1, 1, 1'b0, 1'b1, 0);
        run_line(2, 1, 1'b0, 1'b0, 150);
        run_line(1, 3, 1'b1, 1'b0, 0);
        cmp_en = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule